// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small sum-of-products logic device. A product-term sum arriving from the AND plane is first passed through a programmable inversion, so the cell's output can be active high or active low. The polarity-adjusted value can be used directly, or it can be captured on the global clock and driven from a flip-flop. The pin driver's enable comes from one of four sources picked by a 2-bit code. A feedback line returns a value to the AND plane. Depending on the mode, that value is the inverted flop state, the cell's own pad, the neighbouring cell's pad, or the combinational result.

Three static bits choose among four cell behaviours:
- a device-wide architecture bit,
- this cell's own mode bit,
- the neighbour's mode bit.

With the architecture bit set, the cell is either registered or combinational with pad feedback. With it clear, the cell is either a dedicated input with its driver off, or a plain combinational output. In that last case the feedback borrows the neighbour's pad when the neighbour is itself a dedicated input. A synchronous preload lets a test environment place a known value in the flop. A synchronous reset clears it.

Top module: `out_macrocell`

## Requirements
- R1: When the cell is not registered (cfgArch=0 or cfgCell=0), pinOut equals sumIn XOR cfgPolarity in the same cycle.
- R2: In registered mode (cfgArch=1, cfgCell=1), pinOut shows the value of sumIn XOR cfgPolarity captured at the previous rising clock edge.
- R3: Outside dedicated-input mode, pinOe follows cfgOeSel: 2'b11 gives 1, 2'b10 gives 0, 2'b01 gives gOe, and 2'b00 gives oeTerm.
- R4: In registered mode, fbOut is the inverse of the flop state, so fbOut differs from pinOut.
- R5: In combinational-feedback mode (cfgArch=1, cfgCell=0), fbOut equals pinIn.
- R6: In dedicated-input mode (cfgArch=0, cfgCell=1), pinOe is 0 whatever cfgOeSel holds, and fbOut equals pinIn.
- R7: In plain combinational mode (cfgArch=0, cfgCell=0), fbOut equals nbrPin when cfgNbrCell=1. Otherwise fbOut equals sumIn XOR cfgPolarity.
- R8: A rising clock edge with preloadEn=1 loads preloadVal into the flop in place of the polarity-adjusted sum.
- R9: A rising edge with rst=1 clears the flop to 0, which takes priority over preload. In registered mode this shows as pinOut=0 and fbOut=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Synchronous reset of the flop, active high |
| sumIn | input | 1 | OR of the product terms assigned to this cell |
| oeTerm | input | 1 | Product term reserved for output enable |
| gOe | input | 1 | Global output-enable pin |
| pinIn | input | 1 | Value seen on this cell's pad |
| nbrPin | input | 1 | Value seen on the neighbouring cell's pad |
| cfgPolarity | input | 1 | 1 inverts the sum before use |
| cfgArch | input | 1 | Device-wide architecture bit |
| cfgCell | input | 1 | This cell's mode bit |
| cfgNbrCell | input | 1 | The neighbour's mode bit |
| cfgOeSel | input | 2 | Enable source code |
| preloadEn | input | 1 | Load preloadVal into the flop at the next edge |
| preloadVal | input | 1 | Value for preload |
| pinOut | output | 1 | Pad drive value |
| pinOe | output | 1 | Pad driver enable |
| fbOut | output | 1 | Feedback to the AND plane |

## Verification
All pinOe values are combinational and are due in the same cycle as the stimulus. The same holds for every pinOut and fbOut value outside registered mode. The bench drives inputs on the falling edge and samples those outputs one nanosecond later. Registered pinOut, and the fbOut value derived from it, change one rising edge after the sum, preload or reset is applied. The bench updates its own flop model at that rising edge and compares against it in the following half cycle. The sweep therefore always checks against the state captured at the edge just passed.

// File: rtl/omc_pkg.sv
package omc_pkg;

  typedef enum logic [1:0] {
    OE_TERM = 2'b00,
    OE_PIN  = 2'b01,
    OE_OFF  = 2'b10,
    OE_ON   = 2'b11
  } oeSrc_e;

  typedef enum logic [1:0] {
    FB_QBAR  = 2'b00,
    FB_OWN   = 2'b01,
    FB_NBR   = 2'b10,
    FB_COMB  = 2'b11
  } fbSrc_e;

  typedef struct packed {
    logic   selReg;
    logic   forceOff;
    oeSrc_e oeSrc;
    fbSrc_e fbSrc;
  } cellCtl_t;

endpackage

// File: rtl/omc_ctrl.sv
module omc_ctrl
  import omc_pkg::*;
(
  input  logic       cfgArch,
  input  logic       cfgCell,
  input  logic       cfgNbrCell,
  input  logic [1:0] cfgOeSel,
  output cellCtl_t   ctl
);

  logic regMode;
  logic inMode;

  assign regMode = cfgArch & cfgCell;
  assign inMode  = ~cfgArch & cfgCell;

  always_comb begin
    ctl.selReg   = regMode;
    ctl.forceOff = inMode;
    ctl.oeSrc    = oeSrc_e'(cfgOeSel);
    unique case ({cfgArch, cfgCell})
      2'b11:   ctl.fbSrc = FB_QBAR;
      2'b10:   ctl.fbSrc = FB_OWN;
      2'b01:   ctl.fbSrc = FB_OWN;
      default: ctl.fbSrc = cfgNbrCell ? FB_NBR : FB_COMB;
    endcase
  end

endmodule

// File: rtl/omc_dp.sv
module omc_dp
  import omc_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sumIn,
  input  logic     oeTerm,
  input  logic     gOe,
  input  logic     pinIn,
  input  logic     nbrPin,
  input  logic     cfgPolarity,
  input  logic     preloadEn,
  input  logic     preloadVal,
  input  cellCtl_t ctl,
  output logic     pinOut,
  output logic     pinOe,
  output logic     fbOut
);

  logic xorVal;
  logic qReg;
  logic oeRaw;

  assign xorVal = sumIn ^ cfgPolarity;

  always_ff @(posedge clk) begin
    if (rst)            qReg <= RST_VAL;
    else if (preloadEn) qReg <= preloadVal;
    else                qReg <= xorVal;
  end

  assign pinOut = ctl.selReg ? qReg : xorVal;

  always_comb begin
    unique case (ctl.oeSrc)
      OE_ON:   oeRaw = 1'b1;
      OE_OFF:  oeRaw = 1'b0;
      OE_PIN:  oeRaw = gOe;
      default: oeRaw = oeTerm;
    endcase
  end

  assign pinOe = oeRaw & ~ctl.forceOff;

  always_comb begin
    unique case (ctl.fbSrc)
      FB_QBAR: fbOut = ~qReg;
      FB_OWN:  fbOut = pinIn;
      FB_NBR:  fbOut = nbrPin;
      default: fbOut = xorVal;
    endcase
  end

endmodule

// File: rtl/out_macrocell.sv
module out_macrocell
  import omc_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sumIn,
  input  logic       oeTerm,
  input  logic       gOe,
  input  logic       pinIn,
  input  logic       nbrPin,
  input  logic       cfgPolarity,
  input  logic       cfgArch,
  input  logic       cfgCell,
  input  logic       cfgNbrCell,
  input  logic [1:0] cfgOeSel,
  input  logic       preloadEn,
  input  logic       preloadVal,
  output logic       pinOut,
  output logic       pinOe,
  output logic       fbOut
);

  cellCtl_t ctl;

  omc_ctrl u_ctrl (
    .cfgArch    (cfgArch),
    .cfgCell    (cfgCell),
    .cfgNbrCell (cfgNbrCell),
    .cfgOeSel   (cfgOeSel),
    .ctl        (ctl)
  );

  omc_dp #(.RST_VAL(RST_VAL)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .sumIn       (sumIn),
    .oeTerm      (oeTerm),
    .gOe         (gOe),
    .pinIn       (pinIn),
    .nbrPin      (nbrPin),
    .cfgPolarity (cfgPolarity),
    .preloadEn   (preloadEn),
    .preloadVal  (preloadVal),
    .ctl         (ctl),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .fbOut       (fbOut)
  );

endmodule

// File: rtl/out_macrocell_chk.sv
module out_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic       sumIn,
  input logic       oeTerm,
  input logic       gOe,
  input logic       pinIn,
  input logic       nbrPin,
  input logic       cfgPolarity,
  input logic       cfgArch,
  input logic       cfgCell,
  input logic       cfgNbrCell,
  input logic [1:0] cfgOeSel,
  input logic       preloadEn,
  input logic       preloadVal,
  input logic       pinOut,
  input logic       pinOe,
  input logic       fbOut
);

  logic regMode, cfbMode, inMode, simMode;
  assign regMode = cfgArch & cfgCell;
  assign cfbMode = cfgArch & ~cfgCell;
  assign inMode  = ~cfgArch & cfgCell;
  assign simMode = ~cfgArch & ~cfgCell;

  a_r1_comb_polarity: assert property (@(posedge clk) disable iff (rst)
    !regMode |-> pinOut == (sumIn ^ cfgPolarity));

  a_r2_reg_capture: assert property (@(posedge clk) disable iff (rst)
    !preloadEn |=> (!regMode || pinOut == $past(sumIn ^ cfgPolarity)));

  a_r3_oe_on: assert property (@(posedge clk) disable iff (rst)
    (!inMode && cfgOeSel == 2'b11) |-> pinOe);

  a_r3_oe_off: assert property (@(posedge clk) disable iff (rst)
    (cfgOeSel == 2'b10) |-> !pinOe);

  a_r3_oe_pin: assert property (@(posedge clk) disable iff (rst)
    (!inMode && cfgOeSel == 2'b01) |-> pinOe == gOe);

  a_r3_oe_term: assert property (@(posedge clk) disable iff (rst)
    (!inMode && cfgOeSel == 2'b00) |-> pinOe == oeTerm);

  a_r4_reg_feedback: assert property (@(posedge clk) disable iff (rst)
    regMode |-> fbOut != pinOut);

  a_r5_own_pad: assert property (@(posedge clk) disable iff (rst)
    cfbMode |-> fbOut == pinIn);

  a_r6_input_only: assert property (@(posedge clk) disable iff (rst)
    inMode |-> (!pinOe && fbOut == pinIn));

  a_r7_neighbour: assert property (@(posedge clk) disable iff (rst)
    simMode |-> fbOut == (cfgNbrCell ? nbrPin : (sumIn ^ cfgPolarity)));

  a_r8_preload: assert property (@(posedge clk) disable iff (rst)
    preloadEn |=> (!regMode || pinOut == $past(preloadVal)));

endmodule

bind out_macrocell out_macrocell_chk u_chk (.*);

// File: tb/test_out_macrocell.sv
`timescale 1ns/1ps
module test_out_macrocell;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sumIn = 0, oeTerm = 0, gOe = 0, pinIn = 0, nbrPin = 0;
  logic       cfgPolarity = 0, cfgArch = 0, cfgCell = 0, cfgNbrCell = 0;
  logic [1:0] cfgOeSel = 2'b00;
  logic       preloadEn = 0, preloadVal = 0;
  logic       pinOut, pinOe, fbOut;

  int runCnt = 0;
  int failCnt = 0;
  logic qModel = 1'b0;
  logic lastPre = 1'b0;

  always #4 clk = ~clk;

  out_macrocell i_out_macrocell (
    .clk(clk), .rst(rst), .sumIn(sumIn), .oeTerm(oeTerm), .gOe(gOe),
    .pinIn(pinIn), .nbrPin(nbrPin), .cfgPolarity(cfgPolarity),
    .cfgArch(cfgArch), .cfgCell(cfgCell), .cfgNbrCell(cfgNbrCell),
    .cfgOeSel(cfgOeSel), .preloadEn(preloadEn), .preloadVal(preloadVal),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b (arch=%b cell=%b nbr=%b pol=%b oe=%b)",
               tag, act, exp, cfgArch, cfgCell, cfgNbrCell, cfgPolarity, cfgOeSel);
    end
  endtask

  initial begin
    #(8 * 100000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    // Reset state: registered mode, flop cleared (R9)
    cfgArch = 1; cfgCell = 1; sumIn = 1; preloadEn = 1; preloadVal = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R9 reset pinOut", pinOut, 1'b0);
    check("R9 reset fbOut", fbOut, 1'b1);
    preloadEn = 0;
    rst = 0;
    qModel = 1'b0;

    for (int i = 0; i < 2048; i++) begin
      logic xv, expOe, expFb, regM, cfbM, inM;
      cfgArch     = i[0];
      cfgCell     = i[1];
      cfgNbrCell  = i[2];
      cfgPolarity = i[3];
      cfgOeSel    = i[5:4];
      sumIn       = i[6];
      gOe         = i[7];
      oeTerm      = i[8];
      pinIn       = i[9];
      nbrPin      = i[10];
      preloadEn   = (i % 5 == 2);
      preloadVal  = i[6] ^ i[1];
      #1;
      xv   = sumIn ^ cfgPolarity;
      regM = cfgArch & cfgCell;
      cfbM = cfgArch & ~cfgCell;
      inM  = ~cfgArch & cfgCell;
      case (cfgOeSel)
        2'b11: expOe = 1'b1;
        2'b10: expOe = 1'b0;
        2'b01: expOe = gOe;
        default: expOe = oeTerm;
      endcase
      if (inM) expOe = 1'b0;
      if (regM)      expFb = ~qModel;
      else if (cfbM) expFb = pinIn;
      else if (inM)  expFb = pinIn;
      else           expFb = cfgNbrCell ? nbrPin : xv;

      if (regM) check(lastPre ? "R8 preload out" : "R2 reg out", pinOut, qModel);
      else if (!inM) check("R1 comb out", pinOut, xv);
      check(inM ? "R6 oe forced off" : "R3 oe select", pinOe, expOe);
      if (regM)      check("R4 fb qbar", fbOut, expFb);
      else if (cfbM) check("R5 fb own pad", fbOut, expFb);
      else if (inM)  check("R6 fb pad input", fbOut, expFb);
      else           check("R7 fb neighbour/comb", fbOut, expFb);

      @(posedge clk);
      qModel  = preloadEn ? preloadVal : xv;
      lastPre = preloadEn;
      @(negedge clk);
    end

    // Reset overrides preload (R9)
    cfgArch = 1; cfgCell = 1; preloadEn = 1; preloadVal = 1; rst = 1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R9 reset over preload pinOut", pinOut, 1'b0);
    check("R9 reset over preload fbOut", fbOut, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule